// File: doc/BRIEF.md
# Bit-Band Alias Access Translator

This block sits between a 32-bit bus master and a single-port, word-organised memory. It recognises two address windows. The real window is ordinary storage and is reached with plain word reads and writes. The alias window is 32 times larger, and each aligned word in it stands for one bit of the real window. Reading an alias word returns that one bit. Writing an alias word sets or clears that one bit. The memory is never handed a partial word: the block reads the whole word, changes the bit, and writes the word back. Addresses that fall in neither window are refused with an error response.

The master sees a valid/ready request channel and a valid/ready response channel. Only one request is in flight at a time. Request-ready is high only while the block is idle. It drops on the cycle after a request is accepted and returns only after the response has been taken. Because of this, no second master access can reach the memory between the read and the write-back of a bit update, so the update is atomic. The response is held unchanged while the master keeps response-ready low. The memory port uses a one-cycle synchronous read.

Both window bases must be aligned to their own span. The alias span is the real span times 32. The defaults are a real window of 0x2000_0000 to 0x200F_FFFF and an alias window of 0x2200_0000 to 0x23FF_FFFF.

Top module: `bitband_xlate`

## Requirements
- R1: While reset is held and right after it, req_ready is 1, rsp_valid is 0 and mem_en is 0.
- R2: A read at real address A returns memory word (A - REAL_BASE) >> 2 unchanged, with rsp_err 0, using exactly one memory access.
- R3: A write at real address A stores the full 32-bit write data into memory word (A - REAL_BASE) >> 2, with rsp_err 0 and read data 0, using exactly one memory access.
- R4: An alias address A selects memory word (A - ALIAS_BASE) >> 7 and bit ((A - ALIAS_BASE) >> 2) & 31. This equals a byte offset times 32 plus a bit number times 4.
- R5: An alias read returns the selected bit in bit 0 of rsp_rdata with bits 31..1 zero, makes exactly one memory read and no memory write.
- R6: An alias write sets the selected bit to bit 0 of the write data. Bits 31..1 of the write data are ignored, and every other bit of every memory word keeps its value.
- R7: An alias write performs exactly one read and then one write, to the same word. The write comes two cycles after the read, and no other memory access occurs in between.
- R8: req_ready is 0 from the cycle after a request is accepted until the response has been taken, and the memory is idle whenever req_ready is 1.
- R9: An address in neither window gets rsp_err 1 with rsp_rdata 0 and causes no memory access.
- R10: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_rdata and rsp_err hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data (alias writes use bit 0 only) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Master takes the response |
| rsp_rdata | output | 32 | Read data, 0 for writes and errors |
| rsp_err | output | 1 | Address was in neither window |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | REAL_LOG2-2 | Word index inside the real window |
| mem_wdata | output | 32 | Word to store |
| mem_rdata | input | 32 | Word read, valid the cycle after a read |

## Verification
The bench builds the block with REAL_LOG2 = 8, with the bases left at their default values. This shrinks the real window to 64 words and the alias window to 8 KB. Random traffic therefore revisits the same words and bits often, so read-after-bit-update and repeated updates of one bit are common. Both ends of each window, bit 0 and bit 31 of the first and last words, and the addresses just outside each window are all reachable with short directed requests. The small size also lets the whole memory be compared against the bench's shadow copy after every bit update.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int WORD_W    = 32;
  localparam int BIT_SEL_W = $clog2(WORD_W);

  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_REAL  = 2'd1,
    RG_ALIAS = 2'd2
  } region_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WAIT = 3'd2,
    ST_WR   = 3'd3,
    ST_RSP  = 3'd4
  } state_e;
endpackage

// File: rtl/bb_addr_decode.sv
module bb_addr_decode
  import bb_pkg::*;
#(
  parameter logic [31:0] REAL_BASE  = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int          REAL_LOG2  = 20,
  localparam int         ALIAS_LOG2 = REAL_LOG2 + 5,
  localparam int         IDX_W      = REAL_LOG2 - 2
) (
  input  logic [31:0]          addr,
  output region_e              region,
  output logic [IDX_W-1:0]     word_idx,
  output logic [BIT_SEL_W-1:0] bit_sel
);
  logic real_hit, alias_hit;

  // Window hits compare only the bits above each span
  assign real_hit  = (addr[31:REAL_LOG2]  == REAL_BASE[31:REAL_LOG2]);
  assign alias_hit = (addr[31:ALIAS_LOG2] == ALIAS_BASE[31:ALIAS_LOG2]);

  always_comb begin
    region   = RG_NONE;
    word_idx = '0;
    bit_sel  = '0;
    if (alias_hit) begin
      region   = RG_ALIAS;
      word_idx = addr[ALIAS_LOG2-1:7];
      bit_sel  = addr[6:2];
    end else if (real_hit) begin
      region   = RG_REAL;
      word_idx = addr[REAL_LOG2-1:2];
    end
  end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
  import bb_pkg::*;
(
  input  logic [WORD_W-1:0]    word_in,
  input  logic [BIT_SEL_W-1:0] bit_sel,
  input  logic                 bit_val,
  output logic                 bit_out,
  output logic [WORD_W-1:0]    word_out
);
  always_comb begin
    bit_out  = 1'b0;
    word_out = word_in;
    for (int i = 0; i < WORD_W; i++) begin
      if (bit_sel == BIT_SEL_W'(i)) begin
        bit_out     = word_in[i];
        word_out[i] = bit_val;
      end
    end
  end
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
#(
  parameter int IDX_W = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [WORD_W-1:0]    req_wdata,
  input  region_e              dec_region,
  input  logic [IDX_W-1:0]     dec_idx,
  input  logic [BIT_SEL_W-1:0] dec_bit,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [WORD_W-1:0]    rsp_rdata,
  output logic                 rsp_err,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [IDX_W-1:0]     mem_addr,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic [BIT_SEL_W-1:0] op_bit,
  output logic                 op_bit_val,
  input  logic                 sel_bit,
  input  logic [WORD_W-1:0]    merged_word
);
  state_e               state;
  region_e              op_region;
  logic                 op_write;
  logic [IDX_W-1:0]     op_idx;
  logic [WORD_W-1:0]    word_q;
  logic [WORD_W-1:0]    rdata_q;
  logic                 err_q;

  assign req_ready  = (state == ST_IDLE);
  assign rsp_valid  = (state == ST_RSP);
  assign rsp_rdata  = rdata_q;
  assign rsp_err    = err_q;
  assign mem_en     = (state == ST_RD) || (state == ST_WR);
  assign mem_we     = (state == ST_WR);
  assign mem_addr   = op_idx;
  assign mem_wdata  = word_q;
  assign op_bit_val = word_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_region <= RG_NONE;
      op_write  <= 1'b0;
      op_idx    <= '0;
      op_bit    <= '0;
      word_q    <= '0;
      rdata_q   <= '0;
      err_q     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          op_region <= dec_region;
          op_write  <= req_write;
          op_idx    <= dec_idx;
          op_bit    <= dec_bit;
          word_q    <= req_wdata;
          rdata_q   <= '0;
          err_q     <= 1'b0;
          if (dec_region == RG_NONE) begin
            err_q <= 1'b1;
            state <= ST_RSP;
          end else if (dec_region == RG_REAL && req_write) begin
            state <= ST_WR;
          end else begin
            state <= ST_RD;
          end
        end
        ST_RD:   state <= ST_WAIT;
        ST_WAIT: begin
          if (op_region == RG_REAL) begin
            rdata_q <= mem_rdata;
            state   <= ST_RSP;
          end else if (!op_write) begin
            rdata_q <= {{(WORD_W-1){1'b0}}, sel_bit};
            state   <= ST_RSP;
          end else begin
            word_q  <= merged_word;
            state   <= ST_WR;
          end
        end
        ST_WR:   state <= ST_RSP;
        ST_RSP:  if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
  import bb_pkg::*;
#(
  parameter logic [31:0] REAL_BASE  = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int          REAL_LOG2  = 20,
  localparam int         IDX_W      = REAL_LOG2 - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [31:0]      req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_err,
  output logic             mem_en,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata
);
  region_e              dec_region;
  logic [IDX_W-1:0]     dec_idx;
  logic [BIT_SEL_W-1:0] dec_bit;
  logic [BIT_SEL_W-1:0] op_bit;
  logic                 op_bit_val;
  logic                 sel_bit;
  logic [WORD_W-1:0]    merged_word;

  bb_addr_decode #(
    .REAL_BASE (REAL_BASE),
    .ALIAS_BASE(ALIAS_BASE),
    .REAL_LOG2 (REAL_LOG2)
  ) u_dec (
    .addr    (req_addr),
    .region  (dec_region),
    .word_idx(dec_idx),
    .bit_sel (dec_bit)
  );

  bb_bit_merge u_merge (
    .word_in (mem_rdata),
    .bit_sel (op_bit),
    .bit_val (op_bit_val),
    .bit_out (sel_bit),
    .word_out(merged_word)
  );

  bb_seq #(.IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .dec_region (dec_region),
    .dec_idx    (dec_idx),
    .dec_bit    (dec_bit),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .op_bit     (op_bit),
    .op_bit_val (op_bit_val),
    .sel_bit    (sel_bit),
    .merged_word(merged_word)
  );
endmodule

// File: rtl/bitband_xlate_chk.sv
module bitband_xlate_chk #(
  parameter int IDX_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_rdata,
  input logic             rsp_err,
  input logic             mem_en,
  input logic             mem_we,
  input logic [IDX_W-1:0] mem_addr
);
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R8

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_en); // R8

  AST_RSP_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R10

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 32'd0)); // R9

  AST_READ_THEN_GAP: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |=> !mem_en); // R7

  AST_RMW_SAME_WORD: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && $past(mem_en, 2) && !$past(mem_we, 2))
      |-> (mem_addr == $past(mem_addr, 2))); // R7

  AST_NO_MEM_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_en); // R9
endmodule

bind bitband_xlate bitband_xlate_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata),
  .rsp_err  (rsp_err),
  .mem_en   (mem_en),
  .mem_we   (mem_we),
  .mem_addr (mem_addr)
);

// File: tb/bitband_xlate_test.sv
module bitband_xlate_test;
  localparam logic [31:0] RBASE = 32'h2000_0000;
  localparam logic [31:0] ABASE = 32'h2200_0000;
  localparam int RLOG2  = 8;
  localparam int IDX_W  = RLOG2 - 2;
  localparam int NWORDS = 1 << IDX_W;
  localparam logic [31:0] RSPAN = 32'd1 << RLOG2;
  localparam logic [31:0] ASPAN = RSPAN << 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_write = 1'b0;
  logic [31:0]      req_addr = '0;
  logic [31:0]      req_wdata = '0;
  logic             rsp_valid;
  logic             rsp_ready = 1'b0;
  logic [31:0]      rsp_rdata;
  logic             rsp_err;
  logic             mem_en;
  logic             mem_we;
  logic [IDX_W-1:0] mem_addr;
  logic [31:0]      mem_wdata;
  logic [31:0]      mem_rdata;

  logic [31:0] mem [NWORDS];
  logic [31:0] sh  [NWORDS];
  int nchk = 0, nfail = 0, cyc = 0;
  int nacc, nrd, nwr, rd_cyc, wr_cyc, rd_addr, wr_addr;
  bit done = 0;

  always #2 clk = ~clk;

  bitband_xlate #(.REAL_BASE(RBASE), .ALIAS_BASE(ABASE), .REAL_LOG2(RLOG2)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  function automatic logic [31:0] init_word(int i);
    return (i * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] set_bit(logic [31:0] w, int b, logic v);
    logic [31:0] r = w;
    r[b] = v;
    return r;
  endfunction

  // bench memory: one-cycle synchronous read, loaded during reset
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= init_word(i);
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  always @(posedge clk) if (!rst && mem_en) begin
    nacc = nacc + 1;
    if (mem_we) begin nwr = nwr + 1; wr_cyc = cyc; wr_addr = int'(mem_addr); end
    else        begin nrd = nrd + 1; rd_cyc = cyc; rd_addr = int'(mem_addr); end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                      output logic [31:0] rd, output logic err);
    logic [31:0] first_d; logic first_e; bit seen = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    nacc = 0; nrd = 0; nwr = 0;
    forever begin
      check(!req_ready, "R8 ready while busy", 32'(req_ready), 32'd0);
      rsp_ready = ($urandom_range(0, 2) != 0);
      if (rsp_valid) begin
        if (!seen) begin seen = 1; first_d = rsp_rdata; first_e = rsp_err; end
        else check(rsp_rdata == first_d && rsp_err == first_e, "R10 response hold", rsp_rdata, first_d);
      end
      if (rsp_valid && rsp_ready) break;
      @(negedge clk);
    end
    rd = rsp_rdata; err = rsp_err;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic do_real(input bit wr, input int idx, input logic [31:0] wd);
    logic [31:0] rd; logic err;
    xfer(wr, RBASE + 32'(idx * 4), wd, rd, err);
    check(nacc == 1 && !err, wr ? "R3 real write access" : "R2 real read access", 32'(nacc), 32'd1);
    if (wr) begin
      sh[idx] = wd;
      check(mem[idx] == wd && rd == 0, "R3 real write stored", mem[idx], wd);
    end else begin
      check(rd == sh[idx], "R2 real read data", rd, sh[idx]);
    end
  endtask

  task automatic do_alias(input bit wr, input int idx, input int b, input logic [31:0] wd);
    logic [31:0] rd; logic err; logic [31:0] exp;
    xfer(wr, ABASE + 32'(idx * 128 + b * 4), wd, rd, err);
    if (wr) begin
      sh[idx] = set_bit(sh[idx], b, wd[0]);
      check(!err && nrd == 1 && nwr == 1 && nacc == 2, "R7 one read one write", 32'(nacc), 32'd2);
      check(wr_cyc - rd_cyc == 2, "R7 write two cycles after read", 32'(wr_cyc - rd_cyc), 32'd2);
      check(rd_addr == idx && wr_addr == idx, "R4 alias word select", 32'(wr_addr), 32'(idx));
      for (int i = 0; i < NWORDS; i++)
        if (mem[i] != sh[i]) check(0, "R6 bit update", mem[i], sh[i]);
      check(mem[idx] == sh[idx], "R6 target word", mem[idx], sh[idx]);
    end else begin
      exp = {31'd0, sh[idx][b]};
      check(!err && rd == exp, "R5 alias read bit", rd, exp);
      check(nrd == 1 && nwr == 0, "R5 single read", 32'(nacc), 32'd1);
      check(rd_addr == idx, "R4 alias read word", 32'(rd_addr), 32'(idx));
    end
  endtask

  task automatic do_bad(input logic [31:0] addr, input bit wr);
    logic [31:0] rd; logic err;
    xfer(wr, addr, $urandom, rd, err);
    check(err == 1 && rd == 0, "R9 error response", rd, 32'd0);
    check(nacc == 0, "R9 no memory access", 32'(nacc), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NWORDS; i++) sh[i] = init_word(i);
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_en, "R1 reset state", {req_ready, rsp_valid, mem_en}, 32'h4);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_en, "R1 after reset", {req_ready, rsp_valid, mem_en}, 32'h4);

    // directed corners
    do_real(0, 0, 0);
    do_real(0, NWORDS - 1, 0);
    do_alias(0, 0, 0, 0);
    do_alias(0, NWORDS - 1, 31, 0);
    do_alias(1, 0, 0, 32'hFFFF_FFFE);          // R6 upper bits ignored, clears
    do_alias(1, NWORDS - 1, 31, 32'h0000_0001); // R4 last alias word
    do_alias(1, 3, 17, 32'h0000_0001);
    do_alias(1, 3, 17, 32'h0000_0001);          // R6 setting an already set bit
    do_alias(0, 3, 17, 0);
    do_real(1, 5, 32'hDEAD_BEEF);
    do_alias(0, 5, 0, 0);
    do_bad(RBASE - 4, 0);
    do_bad(RBASE + RSPAN, 1);
    do_bad(ABASE - 4, 1);
    do_bad(ABASE + ASPAN, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k = $urandom_range(0, 9);
      int idx = $urandom_range(0, NWORDS - 1);
      int b = $urandom_range(0, 31);
      if (k < 2)      do_real($urandom_range(0, 1), idx, $urandom);
      else if (k < 5) do_alias(0, idx, b, $urandom);
      else if (k < 9) do_alias(1, idx, b, $urandom);
      else            do_bad($urandom & 32'h0FFF_FFFC, $urandom_range(0, 1));
    end
    for (int i = 0; i < NWORDS; i++) do_real(0, i, 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog R8 actual %h expected %h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule